// File: doc/BRIEF.md
# SPI Receive Queue with Interrupt Routing

This block is the receive half of an SPI peripheral, together with the logic that drives its receive interrupt line. The serial shifter outside the block presents each completed 16-bit word with a one-cycle strobe. A mode input decides where the word goes.

With the mode input low, the word goes into a single holding buffer. That buffer has a ready flag and an overrun flag. With the mode input high, the word goes into a 16-entry queue. The queue has an occupancy count, a programmable threshold and a sticky overflow flag. The CPU side pulses a read strobe. The registered read port then presents the oldest word, or the holding buffer, on the following cycle.

The interrupt output follows the active mode. In single-buffer mode it is formed from the ready flag and the overrun flag, each with its own enable. In queue mode it is formed from the threshold comparison and the overflow flag, both gated by the queue interrupt enable. A queue-clear input holds the queue empty for as long as it is high.

Top module: `spi_rx_irq_route`

## Requirements
- R1: After a synchronous reset: `fifo_count` is 0, `rd_data` is 0, and `rx_rdy`, `rx_ovr`, `fifo_ovf`, `fifo_hit` and `rx_irq` are all 0. The threshold register holds 31, so a full queue (count 16) does not raise `fifo_hit`.
- R2: In queue mode (`fifo_en`=1), each `word_done` pulse stores `word_in` and raises `fifo_count` by one. Each `rd_en` pulse on a non-empty queue loads the oldest stored word into `rd_data` on the next cycle and lowers the count by one. Words come out in arrival order, and the count never exceeds 16.
- R3: In queue mode, a word that arrives while the count is 16 and no read is issued in the same cycle is discarded. The stored contents and the count are unchanged, and `fifo_ovf` is set. `fifo_ovf` stays set until a one-cycle pulse on `ovf_clr`.
- R4: In queue mode, `rd_en` on an empty queue leaves `rd_data` at the last value read and leaves `fifo_count` at 0.
- R5: While `fifo_rst` is 1, the read and write positions and `fifo_count` are held at 0. Arriving words are dropped without setting `fifo_ovf`. After `fifo_rst` returns to 0, the queue refills from empty.
- R6: `fifo_hit` is 1 exactly when `fifo_count` is greater than or equal to the threshold. In queue mode, `rx_irq` = `fifo_ie` AND (`fifo_hit` OR `fifo_ovf`).
- R7: In single-buffer mode (`fifo_en`=0), `word_done` loads the buffer and sets `rx_rdy`. `rd_en` loads the buffer into `rd_data` on the next cycle and clears `rx_rdy`, unless a new word completes in the same cycle. Words never enter the queue in this mode.
- R8: In single-buffer mode, a word that completes while `rx_rdy` is 1 and no read is issued in the same cycle overwrites the buffer and sets `rx_ovr`. `rx_ovr` is cleared only by a pulse on `ovr_clr`.
- R9: In single-buffer mode, `rx_irq` = (`rx_rdy` AND `rx_ie`) OR (`rx_ovr` AND `ovr_ie`). The queue threshold and queue flags have no effect on it.
- R10: In queue mode, a word arriving on a full queue in the same cycle as a read is accepted. The count stays at 16 and `fifo_ovf` is not set.
- R11: A pulse on `lvl_wr` loads `lvl_in` into the threshold register, which takes effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_done | input | 1 | One-cycle strobe: a received word is complete |
| word_in | input | 16 | Completed word from the shifter |
| rd_en | input | 1 | CPU read strobe |
| fifo_en | input | 1 | 1 selects queue mode, 0 selects single-buffer mode |
| fifo_rst | input | 1 | Holds the queue empty while 1 |
| lvl_wr | input | 1 | Threshold load strobe |
| lvl_in | input | 5 | New threshold value |
| ovf_clr | input | 1 | Clears the queue overflow flag |
| ovr_clr | input | 1 | Clears the single-buffer overrun flag |
| rx_ie | input | 1 | Enable for the ready interrupt in single-buffer mode |
| ovr_ie | input | 1 | Enable for the overrun interrupt in single-buffer mode |
| fifo_ie | input | 1 | Enable for the queue interrupts |
| rd_data | output | 16 | Registered read data |
| fifo_count | output | 5 | Number of words in the queue |
| rx_rdy | output | 1 | Single buffer holds an unread word |
| rx_ovr | output | 1 | Single-buffer overrun flag |
| fifo_ovf | output | 1 | Queue overflow flag |
| fifo_hit | output | 1 | Queue count at or above the threshold |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The hardest state to reach from the ports is the full queue. A full queue is needed for three checks: the dropped word, the sticky overflow flag, and the simultaneous read-and-write case that must not overflow. The stimulus pushes sixteen distinct words, then a marker word. It then clears the flag and issues a push together with a pop. Finally it drains the whole queue and compares every word in order, which shows that the marker never entered. A second hard case is a threshold boundary, since the reset threshold is out of reach. The bench loads a threshold of 3 and watches the flag stay low at two words and rise at the third.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;

    localparam int RX_WIDTH = 16;
    localparam int RX_DEPTH = 16;
    localparam int RX_LVL_BITS = 5;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_QUEUE  = 1'b1
    } rx_mode_e;

    typedef struct packed {
        logic rdy;
        logic ovr;
    } single_stat_t;

    typedef struct packed {
        logic ovf;
        logic hit;
    } queue_stat_t;

    function automatic int ptr_next(input int p, input int depth);
        return (p + 1 == depth) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/spi_rx_fifo.sv
module spi_rx_fifo
    import spi_rx_pkg::*;
#(
    parameter int W = RX_WIDTH,
    parameter int DEPTH = RX_DEPTH,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          hold,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    input  logic          ovf_clr,
    output logic [W-1:0]  head,
    output logic          pop_ok,
    output logic [CW-1:0] count,
    output logic          ovf
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          full;
    logic          empty;
    logic          do_push;
    logic          drop;

    always_comb begin
        full    = (count == FULL_CNT);
        empty   = (count == '0);
        pop_ok  = en && pop && !empty && !hold;
        do_push = en && push && !hold && (!full || pop_ok);
        drop    = en && push && !hold && full && !pop_ok;
        head    = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= AW'(ptr_next(int'(wr_ptr), DEPTH));
            end
            if (pop_ok) begin
                rd_ptr <= AW'(ptr_next(int'(rd_ptr), DEPTH));
            end
            count <= count + CW'(do_push) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf <= 1'b0;
        end else if (drop) begin
            ovf <= 1'b1;
        end else if (ovf_clr) begin
            ovf <= 1'b0;
        end
    end

    p_count_cap_r2: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);

    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        !hold |=> (count == $past(count) || count == $past(count) + 1'b1 ||
                   count + 1'b1 == $past(count)));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (en && push && !pop && !hold && count == FULL_CNT) |=> (ovf && count == FULL_CNT));

    p_hold_empty_r5: assert property (@(posedge clk) disable iff (rst)
        hold |=> count == '0);

endmodule

// File: rtl/spi_rx_single.sv
module spi_rx_single
    import spi_rx_pkg::*;
#(
    parameter int W = RX_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    input  logic         ovr_clr,
    output logic [W-1:0] buf_q,
    output single_stat_t stat
);

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q    <= '0;
            stat.rdy <= 1'b0;
        end else if (en) begin
            if (push) begin
                buf_q    <= din;
                stat.rdy <= 1'b1;
            end else if (pop) begin
                stat.rdy <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat.ovr <= 1'b0;
        end else if (en && push && stat.rdy && !pop) begin
            stat.ovr <= 1'b1;
        end else if (ovr_clr) begin
            stat.ovr <= 1'b0;
        end
    end

    p_overrun_r8: assert property (@(posedge clk) disable iff (rst)
        (en && push && stat.rdy && !pop) |=> (stat.ovr && buf_q == $past(din)));

    p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (en && pop && !push) |=> !stat.rdy);

endmodule

// File: rtl/spi_rx_trig.sv
module spi_rx_trig
    import spi_rx_pkg::*;
#(
    parameter int LB = RX_LVL_BITS,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lvl_wr,
    input  logic [LB-1:0] lvl_in,
    input  logic [CW-1:0] count,
    output logic          hit
);

    logic [LB-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '1;
        end else if (lvl_wr) begin
            lvl_q <= lvl_in;
        end
    end

    assign hit = (int'(count) >= int'(lvl_q));

    p_level_load_r11: assert property (@(posedge clk) disable iff (rst)
        lvl_wr |=> (hit == (int'(count) >= int'($past(lvl_in)))));

endmodule

// File: rtl/spi_rx_irq_sel.sv
module spi_rx_irq_sel
    import spi_rx_pkg::*;
(
    input  rx_mode_e     mode,
    input  single_stat_t sstat,
    input  queue_stat_t  qstat,
    input  logic         rx_ie,
    input  logic         ovr_ie,
    input  logic         fifo_ie,
    output logic         irq
);

    always_comb begin
        unique case (mode)
            MODE_QUEUE:  irq = fifo_ie && (qstat.hit || qstat.ovf);
            MODE_SINGLE: irq = (sstat.rdy && rx_ie) || (sstat.ovr && ovr_ie);
            default:     irq = 1'b0;
        endcase
    end

endmodule

// File: rtl/spi_rx_irq_route.sv
module spi_rx_irq_route
    import spi_rx_pkg::*;
#(
    parameter int W = RX_WIDTH,
    parameter int DEPTH = RX_DEPTH,
    parameter int LB = RX_LVL_BITS,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          word_done,
    input  logic [W-1:0]  word_in,
    input  logic          rd_en,
    input  logic          fifo_en,
    input  logic          fifo_rst,
    input  logic          lvl_wr,
    input  logic [LB-1:0] lvl_in,
    input  logic          ovf_clr,
    input  logic          ovr_clr,
    input  logic          rx_ie,
    input  logic          ovr_ie,
    input  logic          fifo_ie,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] fifo_count,
    output logic          rx_rdy,
    output logic          rx_ovr,
    output logic          fifo_ovf,
    output logic          fifo_hit,
    output logic          rx_irq
);

    rx_mode_e     mode;
    single_stat_t sstat;
    queue_stat_t  qstat;
    logic [W-1:0] q_head;
    logic [W-1:0] s_buf;
    logic         q_pop_ok;

    assign mode = rx_mode_e'(fifo_en);

    spi_rx_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .en      (mode == MODE_QUEUE),
        .hold    (fifo_rst),
        .push    (word_done),
        .din     (word_in),
        .pop     (rd_en),
        .ovf_clr (ovf_clr),
        .head    (q_head),
        .pop_ok  (q_pop_ok),
        .count   (fifo_count),
        .ovf     (qstat.ovf)
    );

    spi_rx_single #(.W(W)) u_single (
        .clk     (clk),
        .rst     (rst),
        .en      (mode == MODE_SINGLE),
        .push    (word_done),
        .din     (word_in),
        .pop     (rd_en),
        .ovr_clr (ovr_clr),
        .buf_q   (s_buf),
        .stat    (sstat)
    );

    spi_rx_trig #(.LB(LB), .CW(CW)) u_trig (
        .clk    (clk),
        .rst    (rst),
        .lvl_wr (lvl_wr),
        .lvl_in (lvl_in),
        .count  (fifo_count),
        .hit    (qstat.hit)
    );

    spi_rx_irq_sel u_irq (
        .mode    (mode),
        .sstat   (sstat),
        .qstat   (qstat),
        .rx_ie   (rx_ie),
        .ovr_ie  (ovr_ie),
        .fifo_ie (fifo_ie),
        .irq     (rx_irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            if (mode == MODE_SINGLE) begin
                rd_data <= s_buf;
            end else if (q_pop_ok) begin
                rd_data <= q_head;
            end
        end
    end

    assign rx_rdy   = sstat.rdy;
    assign rx_ovr   = sstat.ovr;
    assign fifo_ovf = qstat.ovf;
    assign fifo_hit = qstat.hit;

    p_empty_read_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && fifo_en && fifo_count == '0) |=> $stable(rd_data));

    p_queue_mask_r6: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && !fifo_ie) |-> !rx_irq);

    p_single_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && !rx_rdy && !rx_ovr) |-> !rx_irq);

    p_single_no_queue_r7: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && !fifo_rst) |=> $stable(fifo_count));

endmodule

// File: tb/tb_spi_rx_irq_route.sv
`timescale 1ns/1ps
module tb_spi_rx_irq_route;

    logic        clk = 1'b0;
    logic        rst;
    logic        word_done, rd_en, fifo_en, fifo_rst, lvl_wr, ovf_clr, ovr_clr;
    logic        rx_ie, ovr_ie, fifo_ie;
    logic [15:0] word_in;
    logic [4:0]  lvl_in;
    logic [15:0] rd_data;
    logic [4:0]  fifo_count;
    logic        rx_rdy, rx_ovr, fifo_ovf, fifo_hit, rx_irq;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    spi_rx_irq_route dut (
        .clk(clk), .rst(rst), .word_done(word_done), .word_in(word_in),
        .rd_en(rd_en), .fifo_en(fifo_en), .fifo_rst(fifo_rst), .lvl_wr(lvl_wr),
        .lvl_in(lvl_in), .ovf_clr(ovf_clr), .ovr_clr(ovr_clr), .rx_ie(rx_ie),
        .ovr_ie(ovr_ie), .fifo_ie(fifo_ie), .rd_data(rd_data),
        .fifo_count(fifo_count), .rx_rdy(rx_rdy), .rx_ovr(rx_ovr),
        .fifo_ovf(fifo_ovf), .fifo_hit(fifo_hit), .rx_irq(rx_irq)
    );

    typedef struct packed {
        logic        push;
        logic        pop;
        logic [15:0] d;
        logic [4:0]  ecnt;
        logic [15:0] erd;
    } vec_t;

    // R2 ordering and R4 empty read, queue mode, default threshold
    localparam vec_t VEC [8] = '{
        '{1'b1, 1'b0, 16'h1111, 5'd1, 16'h0000},
        '{1'b1, 1'b0, 16'h2222, 5'd2, 16'h0000},
        '{1'b1, 1'b0, 16'h3333, 5'd3, 16'h0000},
        '{1'b0, 1'b1, 16'h0000, 5'd2, 16'h1111},
        '{1'b1, 1'b1, 16'h4444, 5'd2, 16'h2222},
        '{1'b0, 1'b1, 16'h0000, 5'd1, 16'h3333},
        '{1'b0, 1'b1, 16'h0000, 5'd0, 16'h4444},
        '{1'b0, 1'b1, 16'h0000, 5'd0, 16'h4444}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic p, input logic r, input logic [15:0] d);
        word_done = p;
        rd_en     = r;
        word_in   = d;
        @(posedge clk);
        @(negedge clk);
        word_done = 1'b0;
        rd_en     = 1'b0;
        lvl_wr    = 1'b0;
        ovf_clr   = 1'b0;
        ovr_clr   = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        word_done = 0; rd_en = 0; fifo_en = 0; fifo_rst = 0; lvl_wr = 0;
        ovf_clr = 0; ovr_clr = 0; rx_ie = 0; ovr_ie = 0; fifo_ie = 0;
        word_in = '0; lvl_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        check("R1 count", 32'(fifo_count), 0);
        check("R1 rd_data", 32'(rd_data), 0);
        check("R1 flags", {27'd0, rx_rdy, rx_ovr, fifo_ovf, fifo_hit, rx_irq}, 0);

        fifo_en = 1'b1;
        fifo_ie = 1'b1;
        foreach (VEC[i]) begin
            step(VEC[i].push, VEC[i].pop, VEC[i].d);
            check($sformatf("R2 vec%0d count", i), 32'(fifo_count), 32'(VEC[i].ecnt));
            check($sformatf("R2 R4 vec%0d rd_data", i), 32'(rd_data), 32'(VEC[i].erd));
        end

        for (int i = 0; i < 16; i++) step(1'b1, 1'b0, 16'hA000 + 16'(i));
        check("R2 full count", 32'(fifo_count), 16);
        check("R1 default threshold no hit", 32'(fifo_hit), 0);
        check("R6 no irq at default threshold", 32'(rx_irq), 0);

        step(1'b1, 1'b0, 16'hDEAD);
        check("R3 drop keeps count", 32'(fifo_count), 16);
        check("R3 ovf set", 32'(fifo_ovf), 1);
        check("R6 ovf drives irq", 32'(rx_irq), 1);
        step(1'b0, 1'b0, 16'h0);
        check("R3 ovf sticky", 32'(fifo_ovf), 1);
        ovf_clr = 1'b1;
        step(1'b0, 1'b0, 16'h0);
        check("R3 ovf cleared", 32'(fifo_ovf), 0);
        check("R6 irq after clear", 32'(rx_irq), 0);

        step(1'b1, 1'b1, 16'hBEEF);
        check("R10 count stays full", 32'(fifo_count), 16);
        check("R10 no ovf", 32'(fifo_ovf), 0);
        check("R10 rd first word", 32'(rd_data), 32'h0000A000);
        for (int i = 1; i < 16; i++) begin
            step(1'b0, 1'b1, 16'h0);
            check($sformatf("R3 drain %0d", i), 32'(rd_data), 32'(16'hA000 + 16'(i)));
        end
        step(1'b0, 1'b1, 16'h0);
        check("R10 R3 last word", 32'(rd_data), 32'h0000BEEF);
        check("R2 drained", 32'(fifo_count), 0);

        lvl_in = 5'd3;
        lvl_wr = 1'b1;
        step(1'b0, 1'b0, 16'h0);
        check("R11 hit at count 0", 32'(fifo_hit), 0);
        step(1'b1, 1'b0, 16'h0C01);
        step(1'b1, 1'b0, 16'h0C02);
        check("R6 below threshold", 32'(fifo_hit), 0);
        check("R6 irq below threshold", 32'(rx_irq), 0);
        step(1'b1, 1'b0, 16'h0C03);
        check("R11 R6 hit at threshold", 32'(fifo_hit), 1);
        check("R6 irq at threshold", 32'(rx_irq), 1);
        fifo_ie = 1'b0;
        #1;
        check("R6 irq masked", 32'(rx_irq), 0);
        fifo_ie = 1'b1;

        fifo_rst = 1'b1;
        step(1'b0, 1'b0, 16'h0);
        check("R5 hold empties", 32'(fifo_count), 0);
        step(1'b1, 1'b0, 16'h0C04);
        check("R5 push dropped", 32'(fifo_count), 0);
        check("R5 no ovf", 32'(fifo_ovf), 0);
        fifo_rst = 1'b0;
        step(1'b1, 1'b0, 16'h5555);
        check("R5 restart count", 32'(fifo_count), 1);
        step(1'b0, 1'b1, 16'h0);
        check("R5 restart data", 32'(rd_data), 32'h00005555);

        lvl_in = 5'd0;
        lvl_wr = 1'b1;
        step(1'b0, 1'b0, 16'h0);
        fifo_en = 1'b0;
        #1;
        check("R9 queue hit present", 32'(fifo_hit), 1);
        check("R9 queue flags ignored", 32'(rx_irq), 0);
        rx_ie = 1'b1;
        step(1'b1, 1'b0, 16'hB001);
        check("R7 rdy set", 32'(rx_rdy), 1);
        check("R9 rdy irq", 32'(rx_irq), 1);
        check("R7 queue untouched", 32'(fifo_count), 0);
        step(1'b0, 1'b1, 16'h0);
        check("R7 read data", 32'(rd_data), 32'h0000B001);
        check("R7 rdy cleared", 32'(rx_rdy), 0);
        check("R9 irq drops", 32'(rx_irq), 0);

        step(1'b1, 1'b0, 16'hB002);
        step(1'b1, 1'b0, 16'hB003);
        check("R8 ovr set", 32'(rx_ovr), 1);
        step(1'b0, 1'b1, 16'h0);
        check("R8 overwrite", 32'(rd_data), 32'h0000B003);
        check("R8 ovr held after read", 32'(rx_ovr), 1);
        rx_ie = 1'b0;
        ovr_ie = 1'b1;
        #1;
        check("R9 ovr irq", 32'(rx_irq), 1);
        ovr_clr = 1'b1;
        step(1'b0, 1'b0, 16'h0);
        check("R8 ovr cleared", 32'(rx_ovr), 0);
        check("R9 irq after ovr clear", 32'(rx_irq), 0);

        step(1'b1, 1'b0, 16'hB004);
        step(1'b1, 1'b1, 16'hB005);
        check("R7 concurrent read data", 32'(rd_data), 32'h0000B004);
        check("R7 concurrent rdy", 32'(rx_rdy), 1);
        check("R8 concurrent no ovr", 32'(rx_ovr), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule